// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns internal memory requests into bus cycles on two 8-bit ports. The low address byte and the data byte share the low port in time. The high port carries either the upper address byte or a page value. Four active-low strobes frame each cycle: an address latch pulse, a program-read strobe, a data-read strobe and a data-write strobe. Five request kinds are accepted over a ready/valid handshake: a program fetch, a read or write through a 16-bit pointer, and a read or write through an 8-bit pointer that takes its upper byte from a page input. Every accepted request completes with one response pulse carrying the read byte.

The block also decides whether a program fetch goes to internal or external memory. The external-fetch pin is sampled while reset is held. If it is low, every later fetch is external. Otherwise a fetch is external only when its address is at or above the internal program size and the bus mode is on.

The bus mode is on only when both configuration bits are 0. In that mode the ports are dedicated to the bus, and internal fetches still show their address while driving zeros in the data phase. With the bus mode off, the ports show two general-purpose output latches, and requests run without touching the pins.

Top module: `extbus_seq`

## Requirements
- R1: An accepted request is followed by one cycle with the address latch output high, then one cycle with it low. In both cycles the low port carries the low address byte, with output enable 1, and the high port carries the upper byte.
- R2: Fetches use the program strobe, 16-bit and 8-bit reads (kind codes 1 and 3) use the read strobe, and writes (codes 2 and 4) use the write strobe. The strobe is low for exactly the 4th and 5th cycles after acceptance. At most one strobe is ever low, and all of them idle high.
- R3: A fetch (kind code 0) places the full 16-bit address on the ports, with its upper byte on the high port.
- R4: An 8-bit-pointer access drives the page value captured at acceptance on the high port for the whole cycle, even if the page input changes afterwards.
- R5: In a write, the write byte is on the low port with output enable 1 from the cycle before the write strobe falls to the cycle after it rises.
- R6: In an external read, the low port's output enable is 0 while the strobe is low. The value on the port-0 input in the last strobe-low cycle is returned as the response data.
- R7: The bus mode is on only for configuration bits 2'b00. The values 01, 10 and 11 select general-purpose mode.
- R8: An internal fetch in bus mode shows its address (R1) and then drives 8'h00 on the low port in the data phase. It asserts no strobe and returns the internal fetch data input.
- R9: In general-purpose mode the ports show the latches last loaded through the latch-write input (reset value 8'hFF). Requests leave the ports unchanged, the address latch output stays low, all strobes stay high, and external reads return 8'h00.
- R10: An external-fetch pin sampled low during reset makes every later fetch external, even at addresses below the internal program size. Sampled high, a fetch is external only at addresses at or above the internal program size.
- R11: Ready is high only when the block is idle. Each accepted request yields exactly one response pulse, in the 6th cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| eaPinN | input | 1 | External-fetch pin, sampled during reset |
| cfgBits | input | 2 | Port configuration; 2'b00 selects bus mode |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready (idle) |
| reqKind | input | 3 | 0 fetch, 1 read16, 2 write16, 3 read8, 4 write8 |
| reqAddr | input | 16 | Request address (low byte only for 8-bit kinds) |
| reqWdata | input | 8 | Write byte |
| pageReg | input | 8 | Page value for 8-bit-pointer accesses |
| intFetchData | input | 8 | Byte from internal program memory |
| rspValid | output | 1 | Response pulse |
| rspData | output | 8 | Response byte |
| gpioWrEn | input | 1 | Load the general-purpose port latches |
| gpioP0Data | input | 8 | Latch value for the low port |
| gpioP2Data | input | 8 | Latch value for the high port |
| p0In | input | 8 | Low port pin input |
| p0Out | output | 8 | Low port output value |
| p0Oe | output | 1 | Low port output enable |
| p2Out | output | 8 | High port output value |
| aleOut | output | 1 | Address latch enable, active high |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |

## Verification
Each request kind is driven in bus mode, each with distinctive address, page and data bytes. A mix-up between the upper address byte and the page, or between strobes, then shows as a wrong pin value in a known phase. Fetches just below and at the internal size boundary separate the internal from the external path. The internal path shows up as a zero data phase and the internal byte coming back. The page input is inverted right after acceptance to show that the page is held. General-purpose mode is tried with all three non-zero configurations, and a second reset with the external-fetch pin low shows that the latched pin forces low addresses external.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    REQ_FETCH = 3'd0,
    REQ_RD16  = 3'd1,
    REQ_WR16  = 3'd2,
    REQ_RD8   = 3'd3,
    REQ_WR8   = 3'd4
  } reqKind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_LATCH,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RELEASE
  } phase_e;

  typedef struct packed {
    logic accept;
    logic showAddr;
    logic dataPhase;
    logic capture;
  } busCtl_t;

endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int INT_PROG_SIZE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eaPinN,
  input  logic              extMode,
  input  logic              reqValid,
  input  reqKind_e          reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output busCtl_t           busCtl,
  output reqKind_e          kindQ,
  output logic              extQ,
  output logic              aleOut,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              rspValid
);

  localparam logic [ADDR_W:0] INT_LIMIT = (ADDR_W+1)'(INT_PROG_SIZE);

  phase_e phase, phaseNext;
  logic   eaForce;
  logic   reqIsFetch;
  logic   reqGoesOut;
  logic   busOn;
  logic   strobeWin;
  logic   kindIsRead;
  logic   kindIsWrite;

  // the external-fetch pin is followed only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) eaForce <= ~eaPinN;
  end

  assign reqIsFetch = (reqKind == REQ_FETCH);
  assign reqGoesOut = reqIsFetch ? (eaForce || (extMode && ({1'b0, reqAddr} >= INT_LIMIT)))
                                 : 1'b1;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:    if (reqValid) phaseNext = PH_ADDR;
      PH_ADDR:    phaseNext = PH_LATCH;
      PH_LATCH:   phaseNext = PH_SETUP;
      PH_SETUP:   phaseNext = PH_STROBE;
      PH_STROBE:  phaseNext = PH_HOLD;
      PH_HOLD:    phaseNext = PH_RELEASE;
      PH_RELEASE: phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      kindQ <= REQ_FETCH;
      extQ  <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (busCtl.accept) begin
        kindQ <= reqKind;
        extQ  <= reqGoesOut;
      end
    end
  end

  assign reqReady = (phase == PH_IDLE);
  assign rspValid = (phase == PH_RELEASE);

  always_comb begin
    busCtl.accept    = (phase == PH_IDLE) && reqValid;
    busCtl.showAddr  = (phase == PH_ADDR) || (phase == PH_LATCH);
    busCtl.dataPhase = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                       (phase == PH_HOLD)  || (phase == PH_RELEASE);
    busCtl.capture   = (phase == PH_HOLD);
  end

  assign busOn       = extMode && extQ;
  assign strobeWin   = (phase == PH_STROBE) || (phase == PH_HOLD);
  assign kindIsRead  = (kindQ == REQ_RD16) || (kindQ == REQ_RD8);
  assign kindIsWrite = (kindQ == REQ_WR16) || (kindQ == REQ_WR8);

  assign aleOut = extMode && (phase == PH_ADDR);
  assign psenN  = !(strobeWin && busOn && (kindQ == REQ_FETCH));
  assign rdN    = !(strobeWin && busOn && kindIsRead);
  assign wrN    = !(strobeWin && busOn && kindIsWrite);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({psenN, rdN, wrN}) >= 2) else $error("more than one strobe low"); // R2

  AST_STROBE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(psenN) || $fell(rdN) || $fell(wrN)) |=> ($countones({psenN, rdN, wrN}) == 2))
    else $error("strobe pulse too short"); // R2

  AST_GPIO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> (!aleOut && psenN && rdN && wrN)) else $error("bus activity in gpio mode"); // R9

  AST_NO_RSP_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady) else $error("response while idle"); // R11

endmodule

// File: rtl/extbus_dp.sv
module extbus_dp
  import extbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  busCtl_t             busCtl,
  input  logic                extMode,
  input  reqKind_e            reqKind,
  input  reqKind_e            kindQ,
  input  logic                extQ,
  input  logic [2*DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   pageReg,
  input  logic [DATA_W-1:0]   p0In,
  input  logic [DATA_W-1:0]   intFetchData,
  input  logic                gpioWrEn,
  input  logic [DATA_W-1:0]   gpioP0Data,
  input  logic [DATA_W-1:0]   gpioP2Data,
  output logic [DATA_W-1:0]   p0Out,
  output logic                p0Oe,
  output logic [DATA_W-1:0]   p2Out,
  output logic [DATA_W-1:0]   rspData
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] addrLoQ, addrHiQ, wdataQ, rspQ, gpioP0Q, gpioP2Q;
  logic              reqShort;
  logic              isWriteQ;

  assign reqShort = (reqKind == REQ_RD8) || (reqKind == REQ_WR8);
  assign isWriteQ = (kindQ == REQ_WR16) || (kindQ == REQ_WR8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLoQ <= '0;
      addrHiQ <= '0;
      wdataQ  <= '0;
      rspQ    <= '0;
      gpioP0Q <= ALL_ONES;
      gpioP2Q <= ALL_ONES;
    end else begin
      if (gpioWrEn) begin
        gpioP0Q <= gpioP0Data;
        gpioP2Q <= gpioP2Data;
      end
      if (busCtl.accept) begin
        addrLoQ <= reqAddr[DATA_W-1:0];
        addrHiQ <= reqShort ? pageReg : reqAddr[2*DATA_W-1:DATA_W];
        wdataQ  <= reqWdata;
      end
      if (busCtl.capture) begin
        if (isWriteQ)     rspQ <= '0;
        else if (!extQ)   rspQ <= intFetchData;
        else if (extMode) rspQ <= p0In;
        else              rspQ <= '0;
      end
    end
  end

  assign rspData = rspQ;

  always_comb begin
    if (!extMode) begin
      p0Out = gpioP0Q;
      p0Oe  = 1'b1;
      p2Out = gpioP2Q;
    end else begin
      p2Out = addrHiQ;
      if (busCtl.showAddr) begin
        p0Out = addrLoQ;
        p0Oe  = 1'b1;
      end else if (busCtl.dataPhase && !extQ) begin
        p0Out = '0;
        p0Oe  = 1'b1;
      end else if (busCtl.dataPhase && isWriteQ) begin
        p0Out = wdataQ;
        p0Oe  = 1'b1;
      end else begin
        p0Out = ALL_ONES;
        p0Oe  = 1'b0;
      end
    end
  end

  AST_HIGH_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busCtl.dataPhase && extMode && $past(extMode)) |-> $stable(p2Out))
    else $error("high port moved during data phase"); // R4

  AST_GPIO_PORTS_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!extMode && $past(!extMode) && $past(!gpioWrEn)) |-> ($stable(p0Out) && $stable(p2Out)))
    else $error("gpio port changed without latch write"); // R9

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int INT_PROG_SIZE = 8192
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                eaPinN,
  input  logic [1:0]          cfgBits,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqKind,
  input  logic [2*DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   pageReg,
  input  logic [DATA_W-1:0]   intFetchData,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  input  logic                gpioWrEn,
  input  logic [DATA_W-1:0]   gpioP0Data,
  input  logic [DATA_W-1:0]   gpioP2Data,
  input  logic [DATA_W-1:0]   p0In,
  output logic [DATA_W-1:0]   p0Out,
  output logic                p0Oe,
  output logic [DATA_W-1:0]   p2Out,
  output logic                aleOut,
  output logic                psenN,
  output logic                rdN,
  output logic                wrN
);

  localparam int ADDR_W = 2 * DATA_W;

  logic     extMode;
  reqKind_e kindIn;
  reqKind_e kindQ;
  logic     extQ;
  busCtl_t  busCtl;

  assign extMode = (cfgBits == 2'b00);
  assign kindIn  = reqKind_e'(reqKind);

  extbus_ctrl #(.ADDR_W(ADDR_W), .INT_PROG_SIZE(INT_PROG_SIZE)) uCtrl (
    .clk(clk), .rstN(rstN), .eaPinN(eaPinN), .extMode(extMode),
    .reqValid(reqValid), .reqKind(kindIn), .reqAddr(reqAddr),
    .reqReady(reqReady), .busCtl(busCtl), .kindQ(kindQ), .extQ(extQ),
    .aleOut(aleOut), .psenN(psenN), .rdN(rdN), .wrN(wrN), .rspValid(rspValid)
  );

  extbus_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .busCtl(busCtl), .extMode(extMode),
    .reqKind(kindIn), .kindQ(kindQ), .extQ(extQ), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .pageReg(pageReg), .p0In(p0In),
    .intFetchData(intFetchData), .gpioWrEn(gpioWrEn),
    .gpioP0Data(gpioP0Data), .gpioP2Data(gpioP2Data),
    .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out), .rspData(rspData)
  );

  AST_ALE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleOut) |-> ($stable(p0Out) && $stable(p2Out) && p0Oe))
    else $error("address moved at latch edge"); // R1

  AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (p0Oe && $stable(p0Out))) else $error("write data not held"); // R5

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !psenN) |-> !p0Oe) else $error("low port driven during read"); // R6

endmodule

// File: tb/tb_extbus_seq.sv
`timescale 1ns/1ps
module tb_extbus_seq;

  localparam int INT_SIZE = 8192;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eaPinN = 1'b1;
  logic [1:0]  cfgBits = 2'b00;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  pageReg = '0;
  logic [7:0]  intFetchData = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        gpioWrEn = 1'b0;
  logic [7:0]  gpioP0Data = '0;
  logic [7:0]  gpioP2Data = '0;
  logic [7:0]  p0In = '0;
  logic [7:0]  p0Out;
  logic        p0Oe;
  logic [7:0]  p2Out;
  logic        aleOut, psenN, rdN, wrN;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expQ[$];
  logic [7:0] gpioP0Exp = 8'hFF;
  logic [7:0] gpioP2Exp = 8'hFF;
  bit eaForceExp = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  extbus_seq #(.DATA_W(8), .INT_PROG_SIZE(INT_SIZE)) dut (
    .clk(clk), .rstN(rstN), .eaPinN(eaPinN), .cfgBits(cfgBits),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .pageReg(pageReg),
    .intFetchData(intFetchData), .rspValid(rspValid), .rspData(rspData),
    .gpioWrEn(gpioWrEn), .gpioP0Data(gpioP0Data), .gpioP2Data(gpioP2Data),
    .p0In(p0In), .p0Out(p0Out), .p0Oe(p0Oe), .p2Out(p2Out),
    .aleOut(aleOut), .psenN(psenN), .rdN(rdN), .wrN(wrN)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // which: 0 none, 1 program strobe, 2 read strobe, 3 write strobe
  task automatic chkStrobes(input int which, input string req);
    chk(req, "psenN", psenN, (which == 1) ? 0 : 1);
    chk(req, "rdN",   rdN,   (which == 2) ? 0 : 1);
    chk(req, "wrN",   wrN,   (which == 3) ? 0 : 1);
  endtask

  // scoreboard monitor: one response per request, compared in order (R11, R6, R8)
  always @(negedge clk) begin
    if (rspValid && rstN) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected response actual=%0h expected=none", rspData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (rspData !== e) begin
          fails++;
          $display("FAIL R6 response data actual=%0h expected=%0h", rspData, e);
        end
      end
    end
  end

  task automatic doReset(input logic ea);
    @(negedge clk);
    rstN = 1'b0;
    eaPinN = ea;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    eaForceExp = !ea;
    gpioP0Exp = 8'hFF;
    gpioP2Exp = 8'hFF;
    @(negedge clk);
    eaPinN = !ea; // pin changes after reset must not matter (R10)
  endtask

  task automatic gpioLoad(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    gpioWrEn = 1'b1; gpioP0Data = a; gpioP2Data = b;
    @(negedge clk);
    gpioWrEn = 1'b0;
    gpioP0Exp = a; gpioP2Exp = b;
  endtask

  task automatic doCycle(input logic [2:0] kind, input logic [15:0] addr,
                         input logic [7:0] wd, input logic [7:0] page,
                         input logic [7:0] extVal, input logic [7:0] intVal);
    bit modeExt, isFetch, isRead, isWrite, isShort, extAcc, busOn;
    int which;
    logic [7:0] expHi, expRsp;
    modeExt = (cfgBits == 2'b00);
    isFetch = (kind == 3'd0);
    isRead  = (kind == 3'd1) || (kind == 3'd3);
    isWrite = (kind == 3'd2) || (kind == 3'd4);
    isShort = (kind == 3'd3) || (kind == 3'd4);
    extAcc  = isFetch ? (eaForceExp || (modeExt && addr >= INT_SIZE)) : 1'b1;
    busOn   = modeExt && extAcc;
    which   = !busOn ? 0 : isFetch ? 1 : isRead ? 2 : 3;
    expHi   = isShort ? page : addr[15:8];
    expRsp  = isWrite ? 8'h00 : !extAcc ? intVal : (modeExt ? extVal : 8'h00);

    @(negedge clk);
    chk("R11", "ready idle", reqReady, 1);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqWdata = wd;
    pageReg = page; p0In = extVal; intFetchData = intVal;
    expQ.push_back(expRsp);
    @(negedge clk); // address phase
    reqValid = 1'b0; pageReg = ~page;
    chk("R11", "ready busy", reqReady, 0);
    if (modeExt) begin
      chk("R1", "ale high", aleOut, 1);
      chk("R1", "low addr", p0Out, addr[7:0]);
      chk("R3", "high byte", p2Out, expHi);
    end else begin
      chk("R9", "ale quiet", aleOut, 0);
      chk("R9", "p0 latch", p0Out, gpioP0Exp);
      chk("R9", "p2 latch", p2Out, gpioP2Exp);
    end
    @(negedge clk); // latch phase
    if (modeExt) begin
      chk("R1", "ale low", aleOut, 0);
      chk("R1", "low addr held", p0Out, addr[7:0]);
      chk("R1", "oe addr", p0Oe, 1);
    end
    @(negedge clk); // setup phase
    chkStrobes(0, "R2");
    if (modeExt && isWrite) chk("R5", "early wdata", p0Out, wd);
    if (modeExt && !extAcc) chk("R8", "zero data", p0Out, 0);
    @(negedge clk); // strobe phase
    chkStrobes(which, "R2");
    chk("R11", "no early rsp", rspValid, 0);
    if (modeExt && isRead) chk("R6", "oe released", p0Oe, 0);
    if (!modeExt) chk("R9", "p0 unchanged", p0Out, gpioP0Exp);
    @(negedge clk); // hold phase
    chkStrobes(which, "R2");
    if (modeExt) chk("R4", "high held", p2Out, expHi);
    else chk("R9", "p2 unchanged", p2Out, gpioP2Exp);
    @(negedge clk); // release phase
    chkStrobes(0, "R2");
    chk("R11", "rsp 6th cycle", rspValid, 1);
    if (modeExt && isWrite) begin
      chk("R5", "late wdata", p0Out, wd);
      chk("R5", "late oe", p0Oe, 1);
    end
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset(1'b1);
    chk("R2", "reset psen", psenN, 1);
    chk("R2", "reset rd", rdN, 1);
    chk("R2", "reset wr", wrN, 1);
    chk("R1", "reset ale", aleOut, 0);
    chk("R11", "reset rsp", rspValid, 0);
    chk("R11", "reset ready", reqReady, 1);

    cfgBits = 2'b00; // R7 bus mode
    doCycle(3'd0, 16'h9A3C, 8'h00, 8'h11, 8'hD7, 8'h42); // R3 external fetch
    doCycle(3'd0, 16'h0123, 8'h00, 8'h11, 8'hD7, 8'h6E); // R8 internal fetch
    doCycle(3'd0, 16'h1FFF, 8'h00, 8'h11, 8'h39, 8'h81); // R10 boundary below
    doCycle(3'd0, 16'h2000, 8'h00, 8'h11, 8'h39, 8'h81); // R10 boundary at
    doCycle(3'd1, 16'h4567, 8'h00, 8'h11, 8'hC4, 8'h00); // R6 read16
    doCycle(3'd2, 16'hBEEF, 8'h5A, 8'h11, 8'h00, 8'h00); // R5 write16
    doCycle(3'd3, 16'hFF77, 8'h00, 8'h3C, 8'h96, 8'h00); // R4 read8
    doCycle(3'd4, 16'h0088, 8'hA1, 8'hC3, 8'h00, 8'h00); // R4 write8

    gpioLoad(8'hA5, 8'h5A);
    foreach (cfgBits[i]) begin end
    cfgBits = 2'b01; // R7 / R9
    @(negedge clk);
    chk("R9", "gpio p0", p0Out, 8'hA5);
    chk("R9", "gpio p2", p2Out, 8'h5A);
    doCycle(3'd1, 16'h4567, 8'h00, 8'h11, 8'hC4, 8'h00);
    cfgBits = 2'b10;
    doCycle(3'd0, 16'h9A3C, 8'h00, 8'h11, 8'hD7, 8'h42);
    cfgBits = 2'b11;
    doCycle(3'd2, 16'h1234, 8'h77, 8'h11, 8'h00, 8'h00);

    doReset(1'b0); // R10 forced external
    cfgBits = 2'b00;
    doCycle(3'd0, 16'h0010, 8'h00, 8'h11, 8'hE2, 8'h1D);
    cfgBits = 2'b01;
    doCycle(3'd0, 16'h0010, 8'h00, 8'h11, 8'hE2, 8'h1D);

    repeat (3) @(negedge clk);
    chk("R11", "all responses seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule